// File: doc/BRIEF.md
# External Instruction Fetch Bus Controller

This block runs instruction fetches from an external program memory over a multiplexed address/data bus. A core hands it a 16-bit fetch address through a valid/ready request channel. The block puts the upper address byte on a dedicated output port. It drives the lower address byte on a shared bus for an external address latch, then releases that bus and reads back the instruction byte. It also produces the address-latch strobe (`ale`) and the active-low read strobe (`psen_n`). Fetch addresses are always a full 16 bits, even when the fitted memory is smaller. The fetch timing is the same in every execution mode, so the block has no mode input.

The block is clocked by a phase clock at twice the system-clock rate, which lets it place edges on half-cycle boundaries. Each fetch takes six phases (three system clocks), numbered 0 to 5. Phase 0 is the first phase-clock cycle after the request is accepted. Odd phases are the high half of the system clock.

- `ale` is high for phases 0 and 1, which is one third of the fetch.
- The new low address appears in phase 1, the middle of the `ale` pulse, and is still on the bus when `ale` falls.
- `psen_n` is low for phases 3 to 5, which is half of the fetch.
- The bus is released on the falling edge of `psen_n`.
- Data is taken at the end of phase 5, the high half of the system clock just before `psen_n` rises.

The shared bus is split into `ad_out`, `ad_oe` and `ad_in`, and the pad ring combines them.

The request channel follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the block is idle and in the last phase of a fetch, so a request waiting there starts the next fetch with no gap. While `req_ready` is low, the requester must hold its request and the block ignores it. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse, and the consumer must take `rsp_data` in that cycle.

Top module: `pfetch_bus_ctrl`

## Requirements
- R1: While `rst` is high and after it is released with no request pending:
  - `ale` = 0, `psen_n` = 1, `ad_oe` = 0, `rsp_valid` = 0 and `req_ready` = 1.
- R2: A request is taken on an edge where `req_valid` and `req_ready` are both high.
  - `req_ready` is 1 when idle and in phase 5. It is 0 in phases 0 to 4.
  - A request raised while `req_ready` is 0 and dropped before phase 5 has no effect: the fetch in flight runs unchanged, `addr_hi` keeps its value and no new `ale` pulse follows.
- R3: `ale` is 1 in phases 0 and 1 of each fetch and 0 in phases 2 to 5.
- R4: `psen_n` is 1 in phases 0 to 2 and 0 in phases 3, 4 and 5.
- R5: The lower address is driven only in phases 1 and 2:
  - In those phases `ad_oe` = 1 and `ad_out` carries address bits [7:0].
  - `ad_oe` is 0 in phase 0 and from phase 3, when `psen_n` falls, onward.
- R6: `addr_hi` carries address bits [15:8] of the accepted request from phase 0 onward. It stays unchanged until the next request is accepted.
- R7: The bus value in phase 5 is captured at the edge that ends phase 5.
  - `rsp_valid` is 1 for exactly the following cycle, with `rsp_data` equal to the captured byte.
  - Bus values in phases 3 and 4, and values after the capture edge, do not change `rsp_data`.
  - `rsp_valid` is not held back by any input.
- R8: A request accepted in phase 5 puts the next fetch in phase 0 in the very next cycle. Back-to-back fetches therefore give one `ale` pulse every six phase clocks.
- R9: If no request is present in phase 5, the block returns to idle in the next cycle and stays there: `ale` = 0, `psen_n` = 1, `ad_oe` = 0, `req_ready` = 1.
- R10: A synchronous reset during a fetch makes the block idle in the next cycle and drops the response. The next accepted request starts again at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the system-clock rate |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 16 | Fetch address |
| rsp_valid | output | 1 | One-cycle pulse: fetched byte available |
| rsp_data | output | 8 | Fetched instruction byte |
| addr_hi | output | 8 | Dedicated upper-address port |
| ad_out | output | 8 | Shared bus output value (lower address) |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input value |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |

## Verification
The two hardest situations to reach are the boundaries between fetches. One is a request that arrives exactly in phase 5, so the next `ale` pulse follows with no idle phase. The other is a request raised in the middle of a fetch, which must be ignored. The stimulus walks each fetch phase by phase, driving and checking at the falling phase-clock edge. It raises the next request exactly in phase 5 for the chained case and only in phases 2 to 3 for the ignored case. In phases 3 and 4 it puts decoy bytes on `ad_in`, and it changes the bus right after the capture edge. This shows that only the phase-5 value reaches `rsp_data`.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;

  localparam int unsigned PH_W = 3;
  typedef logic [PH_W-1:0] phase_t;

  // Phase schedule of one fetch (six phase clocks = three system clocks)
  localparam phase_t PH_FIRST      = 3'd0;
  localparam phase_t PH_ALE_LAST   = 3'd1;  // latch strobe spans phases 0..1
  localparam phase_t PH_DRV_FIRST  = 3'd1;  // low address appears mid-strobe
  localparam phase_t PH_DRV_LAST   = 3'd2;
  localparam phase_t PH_READ_FIRST = 3'd3;  // read strobe low, bus released
  localparam phase_t PH_LAST       = 3'd5;  // capture phase, accept point

  typedef struct packed {
    logic ale;
    logic psen_n;
    logic ad_oe;
  } strobes_t;

  localparam strobes_t STROBES_IDLE = '{ale: 1'b0, psen_n: 1'b1, ad_oe: 1'b0};

  function automatic strobes_t decode_phase(input logic busy, input phase_t ph);
    strobes_t s;
    s.ale    = busy && (ph <= PH_ALE_LAST);
    s.psen_n = !(busy && (ph >= PH_READ_FIRST));
    s.ad_oe  = busy && (ph >= PH_DRV_FIRST) && (ph <= PH_DRV_LAST);
    return s;
  endfunction

endpackage

// File: rtl/pfetch_sequencer.sv
module pfetch_sequencer
  import pfetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              busy_q,
  output phase_t            ph_q,
  output logic              busy_n,
  output phase_t            ph_n,
  output logic [ADDR_W-1:0] addr_q
);

  logic at_last;
  logic accept;

  assign at_last   = busy_q && (ph_q == PH_LAST);
  assign req_ready = !busy_q || at_last;
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (accept) begin
      busy_n = 1'b1;
      ph_n   = PH_FIRST;
    end else if (busy_q && !at_last) begin
      busy_n = 1'b1;
      ph_n   = ph_q + 3'd1;
    end else begin
      busy_n = 1'b0;
      ph_n   = PH_FIRST;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ph_q   <= PH_FIRST;
      addr_q <= '0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      if (accept) addr_q <= req_addr;
    end
  end

endmodule

// File: rtl/pfetch_strobe_gen.sv
module pfetch_strobe_gen
  import pfetch_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   busy_n,
  input  phase_t ph_n,
  output logic   ale,
  output logic   psen_n,
  output logic   ad_oe
);

  strobes_t strb_q;

  // Decode the next state so every strobe leaves a flop directly.
  always_ff @(posedge clk) begin
    if (rst) strb_q <= STROBES_IDLE;
    else     strb_q <= decode_phase(busy_n, ph_n);
  end

  assign ale    = strb_q.ale;
  assign psen_n = strb_q.psen_n;
  assign ad_oe  = strb_q.ad_oe;

endmodule

// File: rtl/pfetch_capture.sv
module pfetch_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_en,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= sample_en;
      if (sample_en) rsp_data <= ad_in;
    end
  end

endmodule

// File: rtl/pfetch_bus_ctrl.sv
module pfetch_bus_ctrl
  import pfetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              psen_n
);

  logic              busy_q;
  logic              busy_n;
  phase_t            ph_q;
  phase_t            ph_n;
  logic [ADDR_W-1:0] addr_q;
  logic              sample_en;

  pfetch_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .busy_q    (busy_q),
    .ph_q      (ph_q),
    .busy_n    (busy_n),
    .ph_n      (ph_n),
    .addr_q    (addr_q)
  );

  pfetch_strobe_gen u_strb (
    .clk    (clk),
    .rst    (rst),
    .busy_n (busy_n),
    .ph_n   (ph_n),
    .ale    (ale),
    .psen_n (psen_n),
    .ad_oe  (ad_oe)
  );

  assign sample_en = busy_q && (ph_q == PH_LAST);

  pfetch_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .ad_in     (ad_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign addr_hi = addr_q[ADDR_W-1:DATA_W];
  assign ad_out  = addr_q[DATA_W-1:0];

endmodule

// File: rtl/pfetch_bus_ctrl_chk.sv
module pfetch_bus_ctrl_chk #(
  parameter int unsigned HI_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            ale,
  input logic            psen_n,
  input logic            ad_oe,
  input logic [HI_W-1:0] addr_hi,
  input logic            rsp_valid
);

  // R2: a latch pulse only starts after a handshake
  p_start_on_accept_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |-> $past(req_valid && req_ready));

  // R3: latch pulse is two phases wide
  p_ale_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale);
  p_ale_end_r3: assert property (@(posedge clk) disable iff (rst)
    (ale && $past(ale)) |=> !ale);

  // R4: read strobe never overlaps the latch strobe or bus drive
  p_read_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (!ale && !ad_oe));
  p_read_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |=> !psen_n);

  // R5: bus is released exactly as the read strobe falls
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |-> $past(ad_oe));

  // R6: upper address moves only after a handshake
  p_hi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> $stable(addr_hi));

  // R7: response pulse coincides with read strobe end, one cycle wide
  p_rsp_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(psen_n));
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

bind pfetch_bus_ctrl pfetch_bus_ctrl_chk #(.HI_W(HI_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ale       (ale),
  .psen_n    (psen_n),
  .ad_oe     (ad_oe),
  .addr_hi   (addr_hi),
  .rsp_valid (rsp_valid)
);

// File: tb/test_pfetch_bus_ctrl.sv
module test_pfetch_bus_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [7:0]  addr_hi;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in = '0;
  logic        ale;
  logic        psen_n;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfetch_bus_ctrl i_pfetch_bus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .psen_n(psen_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " ale"}, ale, 0);
    chk({tag, " psen_n"}, psen_n, 1);
    chk({tag, " ad_oe"}, ad_oe, 0);
    chk({tag, " req_ready"}, req_ready, 1);
  endtask

  // Present a request at a falling edge; it is taken at the next rising edge.
  task automatic issue(input logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    chk("R2 ready before accept", req_ready, 1);
    @(posedge clk);
  endtask

  // Walk phases 0..5 of a fetch that was accepted at the last rising edge.
  task automatic walk(input logic [15:0] a, input logic [7:0] d,
                      input bit chain, input logic [15:0] nxt, input bit poke);
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      if (p == 0) req_valid = 1'b0;
      chk("R3 ale", ale, (p < 2));
      chk("R4 psen_n", psen_n, (p < 3));
      chk("R5 ad_oe", ad_oe, (p == 1 || p == 2));
      if (p == 1 || p == 2) chk("R5 ad_out", ad_out, a[7:0]);
      chk("R6 addr_hi", addr_hi, a[15:8]);
      chk("R2 req_ready", req_ready, (p == 5));
      if (p != 0) chk("R7 rsp_valid idle", rsp_valid, 0);
      ad_in = (p == 5) ? d : (~d ^ 8'(p));
      if (poke && p == 2) begin req_valid = 1'b1; req_addr = ~a; end
      if (poke && p == 3) req_valid = 1'b0;
      if (chain && p == 5) begin req_valid = 1'b1; req_addr = nxt; end
      @(posedge clk);
    end
    #(CLK_PERIOD/4);
    ad_in = ~d;
    #1;
    chk("R7 rsp_valid", rsp_valid, 1);
    chk("R7 rsp_data", rsp_data, d);
  endtask

  task automatic t_reset_state;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 in reset");
    chk("R1 rsp_valid", rsp_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after reset");
    chk("R1 rsp_valid after", rsp_valid, 0);
  endtask

  task automatic t_single_fetch;
    issue(16'hA53C);
    walk(16'hA53C, 8'h96, 1'b0, 16'h0, 1'b0);
    issue(16'h01FE);
    walk(16'h01FE, 8'h00, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic t_back_to_back;
    issue(16'h1234);
    walk(16'h1234, 8'h5A, 1'b1, 16'hFEDC, 1'b0);
    chk("R8 ale restarts at once", ale, 1);
    chk("R8 addr_hi of next", addr_hi, 8'hFE);
    walk(16'hFEDC, 8'hC3, 1'b1, 16'h8001, 1'b0);
    chk("R8 third ale", ale, 1);
    walk(16'h8001, 8'h7E, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic t_idle_return;
    issue(16'h4242);
    walk(16'h4242, 8'h24, 1'b0, 16'h0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk_idle("R9 idle");
      if (i > 0) chk("R9 no response", rsp_valid, 0);
      chk("R9 addr_hi held", addr_hi, 8'h42);
    end
  endtask

  task automatic t_busy_ignore;
    issue(16'h3C0F);
    walk(16'h3C0F, 8'hE1, 1'b0, 16'h0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 ignored req no ale", ale, 0);
      chk("R2 ignored req addr_hi", addr_hi, 8'h3C);
    end
  endtask

  task automatic t_reset_midfetch;
    issue(16'h9988);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_idle("R10 after reset");
    rst = 1'b0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      chk("R10 no response", rsp_valid, 0);
      chk("R10 ale stays low", ale, 0);
    end
    issue(16'h7766);
    walk(16'h7766, 8'h3B, 1'b0, 16'h0, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_single_fetch();
    t_back_to_back();
    t_idle_return();
    t_busy_ignore();
    t_reset_midfetch();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: act=%0h exp=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule